// File: doc/BRIEF.md
# Parallel BCD to Glixon Digit Converter

This block turns one or more packed BCD digits into their Glixon code words. Glixon is a unit-distance decimal code: counting from 0 up to 9 changes exactly one bit per step, and the step from 9 back to 0 also changes one bit. This makes it a good fit for sensors and counters whose value may be sampled at any instant. Each digit lane is built from a few AND, OR and XOR terms that use the checkerboard pattern of the code, and no lookup table is used.

The lanes sit behind a single register stage. A valid strobe passes through with one clock of latency. Any lane that receives a non-decimal value (10 to 15) while the strobe is high raises its own error bit and returns a zero code word, and the other lanes are not affected. When the strobe is low, the registered outputs are cleared.

Top module: `glixon_conv`

## Requirements
- R1: For a legal digit d on a lane, the registered code word is 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1000 for d = 0 through 9 respectively.
- R2: The code words of consecutive digits (d and d+1 for d = 0..8, and 9 followed by 0) differ in exactly one bit.
- R3: Lane i reads in_bcd[4i+3:4i], with bit 4i+3 as the most significant bit. It drives out_code[4i+3:4i] and out_err[i], and a lane's result depends only on its own input nibble.
- R4: out_valid equals the value that in_valid had on the previous rising clock edge.
- R5: When in_valid is high and a lane's nibble is 10 to 15, that lane's out_err bit is 1 and its code word is 0000 on the following cycle.
- R6: When in_valid is high and a lane's nibble is 0 to 9, that lane's out_err bit is 0 on the following cycle.
- R7: When in_valid is low, out_code and out_err are all zero on the following cycle.
- R8: A synchronous active-high reset clears out_valid, out_code and out_err on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input digits are present |
| in_bcd | input | 4*NUM_DIGITS | Packed BCD digits, lane 0 in the lowest nibble |
| out_valid | output | 1 | Registered copy of in_valid |
| out_code | output | 4*NUM_DIGITS | Packed Glixon code words |
| out_err | output | NUM_DIGITS | Per-lane flag for a non-decimal input |

## Verification
The bench builds the converter with NUM_DIGITS = 2. With two lanes, all 256 input pairs can be applied, so every legal and illegal value appears on each lane next to every possible neighbour. This shows that the lanes are independent and that an illegal nibble affects only its own lane. Expected code words are derived in the bench from the Gray-code relation, and the unit-distance property is checked around the full 0 to 9 cycle, including the wrap from 9 back to 0.

// File: rtl/glx_pkg.sv
package glx_pkg;

    localparam int DIGIT_W   = 4;
    localparam int MAX_DIGIT = 9;

    typedef logic [DIGIT_W-1:0] bcd_t;
    typedef logic [DIGIT_W-1:0] glx_t;

    typedef struct packed {
        logic err;
        glx_t code;
    } lane_res_t;

    function automatic logic is_decimal(input bcd_t v);
        return (v <= bcd_t'(MAX_DIGIT));
    endfunction

endpackage

// File: rtl/glx_digit_core.sv
module glx_digit_core
    import glx_pkg::*;
(
    input  bcd_t digit,
    output glx_t code
);
    logic a, b, c, d;

    assign {a, b, c, d} = digit;

    // Weight-8 bit passes straight through.
    assign code[3] = a;
    // Set for digits 4..8.
    assign code[2] = b | (a & ~d);
    // Checkerboard pattern: one XOR gate.
    assign code[1] = b ^ c;
    // Checkerboard pattern in the lower half, cleared for 8 and 9.
    assign code[0] = ~a & (c ^ d);
endmodule

// File: rtl/glx_lane.sv
module glx_lane
    import glx_pkg::*;
(
    input  logic      enable,
    input  bcd_t      digit,
    output lane_res_t res
);
    glx_t raw_code;
    logic legal;

    glx_digit_core u_core (
        .digit (digit),
        .code  (raw_code)
    );

    assign legal = is_decimal(digit);

    always_comb begin
        res.err  = enable & ~legal;
        res.code = (enable & legal) ? raw_code : '0;
    end
endmodule

// File: rtl/glx_out_reg.sv
module glx_out_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             d_valid,
    input  logic [WIDTH-1:0] d_data,
    output logic             q_valid,
    output logic [WIDTH-1:0] q_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= d_valid;
            q_data  <= d_data;
        end
    end
endmodule

// File: rtl/glixon_conv.sv
module glixon_conv
    import glx_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [DIGIT_W*NUM_DIGITS-1:0] in_bcd,
    output logic                          out_valid,
    output logic [DIGIT_W*NUM_DIGITS-1:0] out_code,
    output logic [NUM_DIGITS-1:0]         out_err
);
    localparam int CODE_W = DIGIT_W * NUM_DIGITS;
    localparam int REG_W  = CODE_W + NUM_DIGITS;

    logic [CODE_W-1:0]     next_code;
    logic [NUM_DIGITS-1:0] next_err;
    logic [REG_W-1:0]      reg_q;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_lane
        lane_res_t res;

        glx_lane u_lane (
            .enable (in_valid),
            .digit  (in_bcd[DIGIT_W*i +: DIGIT_W]),
            .res    (res)
        );

        assign next_code[DIGIT_W*i +: DIGIT_W] = res.code;
        assign next_err[i]                     = res.err;
    end

    glx_out_reg #(.WIDTH(REG_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_data  ({next_err, next_code}),
        .q_valid (out_valid),
        .q_data  (reg_q)
    );

    assign out_code = reg_q[CODE_W-1:0];
    assign out_err  = reg_q[REG_W-1:CODE_W];
endmodule

// File: rtl/glx_conv_chk.sv
module glx_conv_chk
    import glx_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic [DIGIT_W*NUM_DIGITS-1:0] in_bcd,
    input logic                          out_valid,
    input logic [DIGIT_W*NUM_DIGITS-1:0] out_code,
    input logic [NUM_DIGITS-1:0]         out_err
);
    // R4
    valid_set_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R4
    valid_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (out_code == '0 && out_err == '0));

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_chk
        // R5
        illegal_lane_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_bcd[DIGIT_W*i +: DIGIT_W] > 4'd9) |=>
            (out_err[i] && out_code[DIGIT_W*i +: DIGIT_W] == '0));

        // R6
        legal_lane_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_bcd[DIGIT_W*i +: DIGIT_W] <= 4'd9) |=> !out_err[i]);

        // R2
        unit_step_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && out_valid && !out_err[i] &&
             in_bcd[DIGIT_W*i +: DIGIT_W] <= 4'd9 &&
             $past(in_valid) && $past(in_bcd[DIGIT_W*i +: DIGIT_W]) <= 4'd9 &&
             (in_bcd[DIGIT_W*i +: DIGIT_W] ==
              (($past(in_bcd[DIGIT_W*i +: DIGIT_W]) == 4'd9) ? 4'd0 :
               $past(in_bcd[DIGIT_W*i +: DIGIT_W]) + 4'd1)))
            |=> ($countones(out_code[DIGIT_W*i +: DIGIT_W] ^
                            $past(out_code[DIGIT_W*i +: DIGIT_W])) == 1));
    end
endmodule

bind glixon_conv glx_conv_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bcd    (in_bcd),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_err   (out_err)
);

// File: tb/sim_glixon_conv.sv
module sim_glixon_conv;
    localparam int CLK_PERIOD = 10;
    localparam int ND         = 2;
    localparam int W          = 4 * ND;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_bcd = '0;
    logic          out_valid;
    logic [W-1:0]  out_code;
    logic [ND-1:0] out_err;

    int checks   = 0;
    int failures = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    glixon_conv #(.NUM_DIGITS(ND)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bcd    (in_bcd),
        .out_valid (out_valid),
        .out_code  (out_code),
        .out_err   (out_err)
    );

    // Glixon word: Gray code for digits up to 8, then 1000 for 9.
    function automatic logic [3:0] ref_code(input int d);
        logic [3:0] v;
        v = 4'(d);
        if (d > 9) return 4'b0000;
        if (d == 9) return 4'b1000;
        return v ^ (v >> 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [W-1:0] data);
        @(negedge clk);
        in_valid = v;
        in_bcd   = data;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [3:0] prev;
        // R8 reset state
        rst = 1'b1;
        in_valid = 1'b1;
        in_bcd = 8'hAF;
        @(posedge clk);
        #1;
        check("R8 valid", 32'(out_valid), 0);
        check("R8 code", 32'(out_code), 0);
        check("R8 err", 32'(out_err), 0);
        @(negedge clk);
        rst = 1'b0;

        // Full sweep of both lanes: R1, R3, R4, R5, R6
        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] exp_code;
            logic [ND-1:0] exp_err;
            drive(1'b1, 8'(v));
            for (int i = 0; i < ND; i++) begin
                int d;
                d = (v >> (4*i)) & 15;
                exp_code[4*i +: 4] = ref_code(d);
                exp_err[i] = (d > 9);
            end
            check("R4 valid", 32'(out_valid), 1);
            check("R1/R3/R5 code", 32'(out_code), 32'(exp_code));
            check("R5/R6 err", 32'(out_err), 32'(exp_err));
        end

        // R7 idle clears outputs, R4 valid drops
        drive(1'b0, 8'h93);
        check("R7 code", 32'(out_code), 0);
        check("R7 err", 32'(out_err), 0);
        check("R4 idle", 32'(out_valid), 0);
        drive(1'b0, 8'hFA);
        check("R7 illegal idle err", 32'(out_err), 0);

        // R2 unit distance around the cycle, including 9 to 0
        drive(1'b1, 8'h00);
        prev = out_code[3:0];
        for (int k = 1; k <= 10; k++) begin
            int d;
            d = k % 10;
            drive(1'b1, {4'(9 - d), 4'(d)});
            check("R2 lane0 step", 32'($countones(out_code[3:0] ^ prev)), 1);
            prev = out_code[3:0];
        end

        // R8 reset mid-stream
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_bcd = 8'h58;
        @(posedge clk);
        #1;
        check("R8 mid valid", 32'(out_valid), 0);
        check("R8 mid code", 32'(out_code), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule